// File: doc/BRIEF.md
# DDR 8b/10b Serial Transmitter

This block sits at the end of a readout data path. It turns a stream of event bytes into a line-coded serial stream that runs at twice the serial clock rate. Bytes arrive with a control-character flag over a valid/ready handshake. Each byte is mapped to a DC-balanced 10-bit symbol by an 8b/10b encoder that tracks running disparity. The symbol is then shifted out as five bit pairs, one pair per serial-clock cycle. In each pair, one bit goes to the rising edge and one to the falling edge of an external double-data-rate output cell. With a 640 MHz serial clock the line carries 1.28 Gbps.

Event records of either width (full time-plus-energy records or shortened timing-only records) reach the block already packed into bytes, so the block does not depend on record size. When no byte is offered at a symbol boundary, the comma idle symbol fills the slot. For link bring-up a test mode replaces the payload with a PRBS-7 byte sequence. That sequence uses the same encoder and serializer, so a receiver can check the full path.

Top module: `ddr_ser_tx`

## Requirements
- R1: While rst_ni is low, rise_o and fall_o are 0, running disparity is negative and the test-pattern generator holds its all-ones seed. The first symbol after reset therefore starts from negative disparity.
- R2: Outside test mode, ready_o is high for exactly one cycle out of every five, and low in the other four. A byte is taken on a rising clock edge where valid_i and ready_o are both high. The first such slot is the first edge after reset is released.
- R3: A symbol loaded at an edge appears on the next five cycles as pairs (rise_o, fall_o) = (a,b), (c,d), (e,i), (f,g), (h,j), using standard 8b/10b bit names. Bit a is sent first.
- R4: With ctrl_i low, data_i is encoded by the standard 8b/10b data code. data_i[4:0] selects the 5b/6b code and data_i[7:5] selects the 3b/4b code, and the alternate x.A7 form is used where the standard rule requires it.
- R5: With ctrl_i high, the bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC (K28.0 to K28.7) and 0xF7, 0xFB, 0xFD, 0xFE (K23.7, K27.7, K29.7, K30.7) produce control symbols. Any other byte with ctrl_i high is encoded as data.
- R6: With negative running disparity, every symbol has 5 or 6 ones. With positive running disparity it has 4 or 5. Disparity flips after any symbol that does not hold exactly 5 ones, and the same rule holds for each 6-bit and 4-bit sub-block.
- R7: When valid_i is low at a load slot outside test mode, the idle symbol K28.5 is sent. It is 0011111010 (a..j) at negative disparity and 1100000101 at positive disparity.
- R8: While prbs_en_i is high, every slot carries a data byte taken from the PRBS-7 generator x^7 + x^6 + 1 (new bit = s[6] ^ s[5], shifted into s[0]). The generator is seeded with all ones and advances eight steps per symbol, and the first bit generated becomes the byte MSB. The first byte after entering the mode is 0x02.
- R9: While prbs_en_i is high, ready_o stays low and valid_i, data_i and ctrl_i have no effect. Whenever prbs_en_i is low, the generator is held at its seed, so each entry into test mode restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to transmit |
| ctrl_i | input | 1 | Byte is a control character |
| valid_i | input | 1 | data_i and ctrl_i are valid |
| ready_o | output | 1 | Byte is taken at this edge if valid |
| prbs_en_i | input | 1 | Replace payload with PRBS-7 bytes |
| rise_o | output | 1 | Bit for the rising-edge half of the cycle |
| fall_o | output | 1 | Bit for the falling-edge half of the cycle |

## Verification
A byte taken at edge N appears on the pins during the five cycles that follow edge N. The last of its pairs is visible in the same cycle in which ready_o rises for the next slot. The bench drives each slot's inputs at the falling edge where ready_o is high, or where ready_o would be high in test mode. It samples one pair at each of the next five falling edges, rebuilds the symbol and decodes it with its own decode tables. It compares the decoded byte, control flag, disparity and exact idle codes with values it derives from the requirements. The sweep covers all 256 data bytes under a running disparity that varies from slot to slot, every control character, invalid control bytes, idle gaps, a full PRBS period and a second entry into test mode.

// File: rtl/ddr_tx_pkg.sv
package ddr_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;
  localparam logic [SYM_W-1:0]  K28_5_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0]  K28_5_POS = 10'b1100000101;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hBC;
endpackage

// File: rtl/enc_8b10b.sv
module enc_8b10b
  import ddr_tx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctrl_i,
  input  logic              rd_i,    // 1 = positive disparity
  output logic [SYM_W-1:0]  sym_o,   // {a,b,c,d,e,i,f,g,h,j}
  output logic              rd_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       k28, kx7, k_ok;
  logic [5:0] base6, code6;
  logic [3:0] base4, code4;
  logic       unb6, unb4, rd_mid, use_alt;

  assign x = byte_i[4:0];
  assign y = byte_i[7:5];
  assign k28  = ctrl_i && (x == 5'd28);
  assign kx7  = ctrl_i && (y == 3'd7) &&
                (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30);
  assign k_ok = k28 || kx7;

  // 5b/6b, negative-disparity form
  always_comb begin
    case (x)
      5'd0:  base6 = 6'b100111;
      5'd1:  base6 = 6'b011101;
      5'd2:  base6 = 6'b101101;
      5'd3:  base6 = 6'b110001;
      5'd4:  base6 = 6'b110101;
      5'd5:  base6 = 6'b101001;
      5'd6:  base6 = 6'b011001;
      5'd7:  base6 = 6'b111000;
      5'd8:  base6 = 6'b111001;
      5'd9:  base6 = 6'b100101;
      5'd10: base6 = 6'b010101;
      5'd11: base6 = 6'b110100;
      5'd12: base6 = 6'b001101;
      5'd13: base6 = 6'b101100;
      5'd14: base6 = 6'b011100;
      5'd15: base6 = 6'b010111;
      5'd16: base6 = 6'b011011;
      5'd17: base6 = 6'b100011;
      5'd18: base6 = 6'b010011;
      5'd19: base6 = 6'b110010;
      5'd20: base6 = 6'b001011;
      5'd21: base6 = 6'b101010;
      5'd22: base6 = 6'b011010;
      5'd23: base6 = 6'b111010;
      5'd24: base6 = 6'b110011;
      5'd25: base6 = 6'b100110;
      5'd26: base6 = 6'b010110;
      5'd27: base6 = 6'b110110;
      5'd28: base6 = 6'b001110;
      5'd29: base6 = 6'b101110;
      5'd30: base6 = 6'b011110;
      default: base6 = 6'b101011;
    endcase
    if (k28) base6 = 6'b001111;
  end

  assign unb6   = ($countones(base6) != 3);
  assign code6  = (rd_i && (unb6 || x == 5'd7)) ? ~base6 : base6;
  assign rd_mid = unb6 ? ~rd_i : rd_i;

  // alternate 7 avoids a run of five equal bits across the sub-block seam
  assign use_alt = (y == 3'd7) &&
                   (k_ok ||
                    (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                    ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));

  always_comb begin
    case (y)
      3'd0: base4 = 4'b1011;
      3'd1: base4 = 4'b1001;
      3'd2: base4 = 4'b0101;
      3'd3: base4 = 4'b1100;
      3'd4: base4 = 4'b1101;
      3'd5: base4 = 4'b1010;
      3'd6: base4 = 4'b0110;
      default: base4 = 4'b1110;
    endcase
    if (use_alt) base4 = 4'b0111;
  end

  assign unb4 = ($countones(base4) != 2);

  always_comb begin
    code4 = base4;
    if (rd_mid && (unb4 || y == 3'd3)) code4 = ~base4;
    // K28 balanced codes take the opposite polarity to data
    if (k28 && !unb4 && y != 3'd3 && !rd_mid) code4 = ~base4;
  end

  assign rd_o  = unb4 ? ~rd_mid : rd_mid;
  assign sym_o = {code6, code4};
endmodule

// File: rtl/prbs7_byte.sv
module prbs7_byte #(
  parameter int ORDER = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6,
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] byte_o
);
  logic [ORDER-1:0] lfsr_q, lfsr_nxt;

  always_comb begin
    logic [ORDER-1:0] s;
    logic             nb;
    s      = lfsr_q;
    byte_o = '0;
    for (int i = 0; i < OUT_W; i++) begin
      nb = s[TAP_A-1] ^ s[TAP_B-1];
      byte_o[OUT_W-1-i] = nb;
      s = {s[ORDER-2:0], nb};
    end
    lfsr_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= '1;
    else if (clear_i) lfsr_q <= '1;
    else if (step_i)  lfsr_q <= lfsr_nxt;
  end
endmodule

// File: rtl/ddr_tx_serializer.sv
module ddr_tx_serializer #(
  parameter int SYM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  output logic             last_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int LANES = 2;
  localparam int SLOTS = SYM_W / LANES;
  localparam int PH_W  = $clog2(SLOTS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);

  logic [PH_W-1:0]  ph_q;
  logic [SYM_W-1:0] sh_q;

  assign last_o = (ph_q == PH_LAST);
  assign rise_o = sh_q[SYM_W-1];
  assign fall_o = sh_q[SYM_W-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_LAST;
      sh_q <= '0;
    end else if (last_o) begin
      ph_q <= '0;
      sh_q <= sym_i;
    end else begin
      ph_q <= ph_q + 1'b1;
      sh_q <= {sh_q[SYM_W-LANES-1:0], {LANES{1'b0}}};
    end
  end
endmodule

// File: rtl/ddr_ser_tx.sv
module ddr_ser_tx
  import ddr_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ctrl_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              prbs_en_i,
  output logic              rise_o,
  output logic              fall_o
);
  logic              last;
  logic              rd_q;
  logic              enc_rd;
  logic [SYM_W-1:0]  enc_sym;
  logic [BYTE_W-1:0] prbs_byte, sel_byte;
  logic              sel_ctrl;

  assign ready_o = last && !prbs_en_i;

  always_comb begin
    if (prbs_en_i) begin
      sel_byte = prbs_byte;
      sel_ctrl = 1'b0;
    end else if (valid_i) begin
      sel_byte = data_i;
      sel_ctrl = ctrl_i;
    end else begin
      sel_byte = IDLE_BYTE;
      sel_ctrl = 1'b1;
    end
  end

  prbs7_byte #(.ORDER(7), .TAP_A(7), .TAP_B(6), .OUT_W(BYTE_W)) u_prbs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!prbs_en_i),
    .step_i  (last && prbs_en_i),
    .byte_o  (prbs_byte)
  );

  enc_8b10b u_enc (
    .byte_i (sel_byte),
    .ctrl_i (sel_ctrl),
    .rd_i   (rd_q),
    .sym_o  (enc_sym),
    .rd_o   (enc_rd)
  );

  ddr_tx_serializer #(.SYM_W(SYM_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sym_i  (enc_sym),
    .last_o (last),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= 1'b0;
    else if (last) rd_q <= enc_rd;
  end
endmodule

// File: rtl/ddr_tx_checker.sv
module ddr_tx_checker
  import ddr_tx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             last_i,
  input logic             ready_i,
  input logic             valid_i,
  input logic             prbs_en_i,
  input logic             rd_i,
  input logic [SYM_W-1:0] enc_sym_i,
  input logic             rise_i,
  input logic             fall_i
);
  p_ready_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  p_first_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (rise_i == $past(enc_sym_i[SYM_W-1]) && fall_i == $past(enc_sym_i[SYM_W-2])));

  p_sym_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !rd_i) |-> ($countones(enc_sym_i) == 5 || $countones(enc_sym_i) == 6));

  p_sym_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && rd_i) |-> ($countones(enc_sym_i) == 4 || $countones(enc_sym_i) == 5));

  p_rd_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> ((rd_i != $past(rd_i)) == ($countones($past(enc_sym_i)) != 5)));

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(rd_i));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !prbs_en_i && !valid_i) |-> (enc_sym_i == (rd_i ? K28_5_POS : K28_5_NEG)));

  p_no_ready_prbs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_en_i |-> !ready_i);
endmodule

bind ddr_ser_tx ddr_tx_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .last_i    (last),
  .ready_i   (ready_o),
  .valid_i   (valid_i),
  .prbs_en_i (prbs_en_i),
  .rd_i      (rd_q),
  .enc_sym_i (enc_sym),
  .rise_i    (rise_o),
  .fall_i    (fall_o)
);

// File: tb/tb_ddr_ser_tx.sv
module tb_ddr_ser_tx;
  localparam time CLK_PERIOD = 10;
  localparam int  N_SLOTS = 691;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] data_i;
  logic       ctrl_i, valid_i, prbs_en_i;
  logic       ready_o, rise_o, fall_o;

  int  vec_cnt = 0;
  int  err_cnt = 0;
  bit  done = 1'b0;
  logic       rd_b;
  logic [6:0] lf;
  logic       prev_p;
  logic [10:0] exp_q[$];   // {prbs_first, idle, ctrl, byte}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_ser_tx dut (
    .clk_i, .rst_ni, .data_i, .ctrl_i, .valid_i, .ready_o,
    .prbs_en_i, .rise_o, .fall_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_kx(input logic [4:0] x);
    return x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30;
  endfunction

  // R5: legal control bytes
  function automatic bit k_legal(input logic [7:0] b);
    return (b[4:0] == 5'd28) || (b[7:5] == 3'd7 && is_kx(b[4:0]));
  endfunction

  function automatic logic [7:0] k_list(input int i);
    case (i)
      0: return 8'h1C;  1: return 8'h3C;  2: return 8'h5C;  3: return 8'h7C;
      4: return 8'h9C;  5: return 8'hBC;  6: return 8'hDC;  7: return 8'hFC;
      8: return 8'hF7;  9: return 8'hFB; 10: return 8'hFD; default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [7:0] bad_k(input int i);
    case (i)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'hB5; default: return 8'h1B;
    endcase
  endfunction

  task automatic plan(input int n, output logic v, output logic k,
                      output logic p, output logic [7:0] b);
    v = 1'b1; k = 1'b0; p = 1'b0; b = 8'h00;
    if (n == 0) v = 1'b0;
    else if (n <= 256) begin b = 8'(n - 1); v = (n % 37 != 0); end
    else if (n <= 268) begin b = k_list(n - 257); k = 1'b1; end
    else if (n <= 272) begin b = bad_k(n - 269); k = 1'b1; end
    else if (n <= 528) begin b = 8'(n - 273) ^ 8'hA5; v = (n % 29 != 0); end
    else if (n <= 668) begin p = 1'b1; b = 8'h55; end
    else if (n <= 676) b = 8'(n);
    else if (n <= 680) begin p = 1'b1; k = 1'b1; b = 8'hBC; end
    else v = 1'b0;
  endtask

  // R8 model: new bit = s[6]^s[5], first bit into MSB
  task automatic prbs_step(inout logic [6:0] s, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      b[i] = s[6] ^ s[5];
      s = {s[5:0], b[i]};
    end
  endtask

  function automatic logic [6:0] dec6(input logic [5:0] c); // {ok,k28,x}
    case (c)
      6'b100111, 6'b011000: return {2'b10, 5'd0};
      6'b011101, 6'b100010: return {2'b10, 5'd1};
      6'b101101, 6'b010010: return {2'b10, 5'd2};
      6'b110001:            return {2'b10, 5'd3};
      6'b110101, 6'b001010: return {2'b10, 5'd4};
      6'b101001:            return {2'b10, 5'd5};
      6'b011001:            return {2'b10, 5'd6};
      6'b111000, 6'b000111: return {2'b10, 5'd7};
      6'b111001, 6'b000110: return {2'b10, 5'd8};
      6'b100101:            return {2'b10, 5'd9};
      6'b010101:            return {2'b10, 5'd10};
      6'b110100:            return {2'b10, 5'd11};
      6'b001101:            return {2'b10, 5'd12};
      6'b101100:            return {2'b10, 5'd13};
      6'b011100:            return {2'b10, 5'd14};
      6'b010111, 6'b101000: return {2'b10, 5'd15};
      6'b011011, 6'b100100: return {2'b10, 5'd16};
      6'b100011:            return {2'b10, 5'd17};
      6'b010011:            return {2'b10, 5'd18};
      6'b110010:            return {2'b10, 5'd19};
      6'b001011:            return {2'b10, 5'd20};
      6'b101010:            return {2'b10, 5'd21};
      6'b011010:            return {2'b10, 5'd22};
      6'b111010, 6'b000101: return {2'b10, 5'd23};
      6'b110011, 6'b001100: return {2'b10, 5'd24};
      6'b100110:            return {2'b10, 5'd25};
      6'b010110:            return {2'b10, 5'd26};
      6'b110110, 6'b001001: return {2'b10, 5'd27};
      6'b001110:            return {2'b10, 5'd28};
      6'b101110, 6'b010001: return {2'b10, 5'd29};
      6'b011110, 6'b100001: return {2'b10, 5'd30};
      6'b101011, 6'b010100: return {2'b10, 5'd31};
      6'b001111, 6'b110000: return {2'b11, 5'd28};
      default:              return 7'd0;
    endcase
  endfunction

  function automatic logic [4:0] dec4(input logic [3:0] c); // {ok,alt,y}
    case (c)
      4'b1011, 4'b0100: return {2'b10, 3'd0};
      4'b1001:          return {2'b10, 3'd1};
      4'b0101:          return {2'b10, 3'd2};
      4'b1100, 4'b0011: return {2'b10, 3'd3};
      4'b1101, 4'b0010: return {2'b10, 3'd4};
      4'b1010:          return {2'b10, 3'd5};
      4'b0110:          return {2'b10, 3'd6};
      4'b1110, 4'b0001: return {2'b10, 3'd7};
      4'b0111, 4'b1000: return {2'b11, 3'd7};
      default:          return 5'd0;
    endcase
  endfunction

  task automatic check_symbol(input logic [9:0] s);
    logic [10:0] e;
    logic [6:0]  d6;
    logic [4:0]  d4;
    logic [3:0]  c4;
    logic        kd;
    logic [8:0]  got;
    int          o6, o4;
    bit          ok6, ok4;
    string       req;
    e  = exp_q.pop_front();
    d6 = dec6(s[9:4]);
    c4 = s[3:0];
    if (s[9:4] == 6'b110000 && $countones(c4) == 2 && c4 != 4'b1100 && c4 != 4'b0011)
      c4 = ~c4;
    d4  = dec4(c4);
    kd  = d6[5] || (d4[3] && is_kx(d6[4:0]));
    got = {kd, d4[2:0], d6[4:0]};
    req = e[9] ? "R7" : (e[10] || (!e[8] && exp_q.size() > 0 && 0)) ? "R8" : e[8] ? "R5" : "R4";
    check(d6[6] && d4[4], "R3", "symbol not a legal code", {6'd0, s}, 16'h0);
    check(got == e[8:0], req, "decoded {ctrl,byte}", {7'd0, got}, {7'd0, e[8:0]});
    if (e[9])
      check(s == (rd_b ? 10'b1100000101 : 10'b0011111010), "R7", "idle pattern",
            {6'd0, s}, {6'd0, (rd_b ? 10'b1100000101 : 10'b0011111010)});
    if (e[10])
      check(got[7:0] == 8'h02, "R8", "first test byte", {8'd0, got[7:0]}, 16'h0002);
    // R6: sub-block disparity rules
    o6  = $countones(s[9:4]);
    ok6 = rd_b ? (o6 == 2 || o6 == 3) : (o6 == 3 || o6 == 4);
    if (s[9:4] == 6'b111000 && rd_b)  ok6 = 1'b0;
    if (s[9:4] == 6'b000111 && !rd_b) ok6 = 1'b0;
    if (o6 != 3) rd_b = ~rd_b;
    o4  = $countones(s[3:0]);
    ok4 = rd_b ? (o4 == 1 || o4 == 2) : (o4 == 2 || o4 == 3);
    if (s[3:0] == 4'b1100 && rd_b)  ok4 = 1'b0;
    if (s[3:0] == 4'b0011 && !rd_b) ok4 = 1'b0;
    if (o4 != 2) rd_b = ~rd_b;
    check(ok6 && ok4, "R6", "disparity", {6'd0, s}, {15'd0, rd_b});
  endtask

  initial begin
    logic       v, k, p;
    logic [7:0] b;
    logic [9:0] sym;
    logic [10:0] ent;
    logic [7:0] pb;
    rst_ni = 1'b0; data_i = '0; ctrl_i = 1'b0; valid_i = 1'b0; prbs_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(rise_o == 1'b0 && fall_o == 1'b0, "R1", "outputs in reset",
          {14'd0, rise_o, fall_o}, 16'h0);
    rst_ni = 1'b1;
    rd_b = 1'b0; lf = 7'h7F; prev_p = 1'b0;
    for (int n = 0; n < N_SLOTS; n++) begin
      plan(n, v, k, p, b);
      valid_i = v; ctrl_i = k; data_i = b; prbs_en_i = p;
      #1;
      check(ready_o == !p, p ? "R9" : "R2", "ready at slot", {15'd0, ready_o}, {15'd0, !p});
      if (p) begin
        prbs_step(lf, pb);
        ent = {!prev_p, 1'b0, 1'b0, pb};
      end else begin
        lf = 7'h7F;
        if (v) ent = {2'b00, k && k_legal(b), b};
        else   ent = {2'b01, 1'b1, 8'hBC};
      end
      exp_q.push_back(ent);
      prev_p = p;
      // R3: pairs arrive on the five cycles after the load edge
      sym = '0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk_i);
        sym = {sym[7:0], rise_o, fall_o};
        if (i < 4)
          check(ready_o == 1'b0, "R2", "ready between slots", {15'd0, ready_o}, 16'h0);
      end
      check_symbol(sym);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      vec_cnt++;
      err_cnt++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule